// File: doc/BRIEF.md
# D-PHY Clock Lane Sequencer

This block drives the transmit side of a high-speed serial clock lane. From the low-power stop state it walks the lane through a bridge phase (LP-00) and a high-speed zero phase (HS-0), then into continuous clock toggling. On the way back it runs a tail of toggling, a high-speed zero trail, and a guarded return to the stop state (LP-11). Its output is a two-bit line-state code for a downstream serializer. An external unit converts picosecond limits into core-clock cycles, and every interval reaches the block as a cycle count.

The data lanes are interlocked with the clock. The data side raises a one-cycle `burst_start` pulse. The sequencer asserts `data_go` only after the clock has toggled for the pre-interval, and only then may data lanes begin their own high-speed entry. When the last data lane has finished its trail, the data side pulses `burst_end`. The clock keeps toggling for the post-interval, counted from that point, before the clock trail begins.

The states are IDLE (LP-11), PREP (LP-00), ZERO (HS-0), PRE (toggle, not ready), RUN (toggle, ready), POST (toggle, not ready), TRAIL (HS-0) and EXIT (LP-11 guard). The transitions are:
- IDLE→PREP on a start pulse.
- PREP→ZERO, ZERO→PRE, PRE→RUN, POST→TRAIL and TRAIL→EXIT when the interval counter reaches zero.
- RUN→POST on a stop pulse or on a stop latched earlier.
- EXIT→PREP when the counter reaches zero and a start is pending or arriving; otherwise EXIT→IDLE.

Top module: `dphy_clk_seq`

## Requirements
- R1: After reset `line_state` is 2'b00 (LP-11) and `data_go` is 0, and the lane stays in LP-11 while no start pulse arrives.
- R2: A start pulse seen in IDLE moves the lane to 2'b01 (LP-00) on the next cycle. LP-00 lasts `cfg_prepare`+1 cycles and is entered only from LP-11.
- R3: After LP-00, the lane drives 2'b10 (HS-0) for `cfg_zero`+1 cycles.
- R4: After HS-0, the lane drives 2'b11 (toggling) with `data_go` low for `cfg_pre`+1 cycles. `data_go` is then raised, and it is high only while the lane toggles.
- R5: A stop pulse seen while `data_go` is high lowers `data_go` on the next cycle. Toggling then continues, with `data_go` low, for `cfg_post`+1 cycles.
- R6: After the post tail, the lane drives HS-0 for `cfg_trail`+1 cycles and then LP-11. LP-11 after a burst is entered only from HS-0.
- R7: After a burst, LP-11 is held for `cfg_exit`+1 cycles. A start pulse arriving in that window is held, and LP-00 follows immediately when the window closes.
- R8: A start pulse arriving between LP-00 entry and the end of the trail is dropped, so no second burst follows without a new start.
- R9: A stop pulse arriving during LP-00, HS-0 or the pre-interval is deferred. `data_go` is then high for exactly one cycle.
- R10: A stop pulse arriving while the lane is in LP-11 has no effect on the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | One-cycle request to start clocking |
| burst_end | input | 1 | One-cycle notice that the last data lane finished its trail |
| cfg_prepare | input | CNT_W | LP-00 length minus one, in cycles |
| cfg_zero | input | CNT_W | HS-0 lead-in length minus one |
| cfg_pre | input | CNT_W | Toggling before release, minus one |
| cfg_post | input | CNT_W | Toggling after stop, minus one |
| cfg_trail | input | CNT_W | HS-0 trail length minus one |
| cfg_exit | input | CNT_W | LP-11 guard length minus one |
| line_state | output | 2 | 00 LP-11, 01 LP-00, 10 HS-0, 11 toggling |
| data_go | output | 1 | Data lanes may begin high-speed entry |

## Verification
Two functions can fall in the same cycle: the guard timer of EXIT can expire on the very edge that a new start pulse is sampled, and a deferred stop can be consumed on the edge where the pre-interval ends. The bench provokes both by sweeping every interval over 0, 1 and 4. A zero guard makes the start pulse land on the expiring cycle. Stop pulses are placed during LP-00 so that they coincide with the release into RUN. It judges them by run lengths: LP-11 must last exactly guard+1 cycles, and `data_go` must be high for exactly one cycle.

// File: rtl/dphy_clk_pkg.sv
package dphy_clk_pkg;

    typedef enum logic [1:0] {
        LS_STOP    = 2'b00,
        LS_BRIDGE  = 2'b01,
        LS_HS_ZERO = 2'b10,
        LS_HS_CLK  = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_ZERO,
        S_PRE,
        S_RUN,
        S_POST,
        S_TRAIL,
        S_EXIT
    } seq_t;

endpackage

// File: rtl/dphy_clk_timer.sv
module dphy_clk_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TIMER_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired); // R2

endmodule

// File: rtl/dphy_clk_reqlatch.sv
module dphy_clk_reqlatch (
    input  logic clk,
    input  logic rst_n,
    input  logic start_in,
    input  logic stop_in,
    input  logic take_start,
    input  logic clr_start,
    input  logic take_stop,
    input  logic clr_stop,
    output logic start_pend,
    output logic stop_pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
            stop_pend  <= 1'b0;
        end else begin
            if (clr_start)
                start_pend <= 1'b0;
            else if (take_start && start_in)
                start_pend <= 1'b1;
            if (clr_stop)
                stop_pend <= 1'b0;
            else if (take_stop && stop_in)
                stop_pend <= 1'b1;
        end
    end

    AST_START_PEND_ONLY_IN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        start_pend |-> take_start); // R7

endmodule

// File: rtl/dphy_clk_seq.sv
module dphy_clk_seq
    import dphy_clk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_start,
    input  logic             burst_end,
    input  logic [CNT_W-1:0] cfg_prepare,
    input  logic [CNT_W-1:0] cfg_zero,
    input  logic [CNT_W-1:0] cfg_pre,
    input  logic [CNT_W-1:0] cfg_post,
    input  logic [CNT_W-1:0] cfg_trail,
    input  logic [CNT_W-1:0] cfg_exit,
    output logic [1:0]       line_state,
    output logic             data_go
);
    seq_t             state, nxt;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             start_pend, stop_pend;
    logic             in_guard, in_lead;
    line_t            line_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (burst_start) nxt = S_PREP;
            S_PREP:  if (tmr_zero) nxt = S_ZERO;
            S_ZERO:  if (tmr_zero) nxt = S_PRE;
            S_PRE:   if (tmr_zero) nxt = S_RUN;
            S_RUN:   if (stop_pend || burst_end) nxt = S_POST;
            S_POST:  if (tmr_zero) nxt = S_TRAIL;
            S_TRAIL: if (tmr_zero) nxt = S_EXIT;
            S_EXIT:  if (tmr_zero) nxt = (start_pend || burst_start) ? S_PREP : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // interval selection, loaded on every state change
    always_comb begin
        tmr_val = '0;
        unique case (nxt)
            S_PREP:  tmr_val = cfg_prepare;
            S_ZERO:  tmr_val = cfg_zero;
            S_PRE:   tmr_val = cfg_pre;
            S_POST:  tmr_val = cfg_post;
            S_TRAIL: tmr_val = cfg_trail;
            S_EXIT:  tmr_val = cfg_exit;
            default: tmr_val = '0;
        endcase
    end

    assign tmr_load = (nxt != state);
    assign in_guard = (state == S_EXIT);
    assign in_lead  = (state == S_PREP) || (state == S_ZERO) || (state == S_PRE);

    dphy_clk_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    dphy_clk_reqlatch u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_in   (burst_start),
        .stop_in    (burst_end),
        .take_start (in_guard),
        .clr_start  (in_guard && nxt != S_EXIT),
        .take_stop  (in_lead),
        .clr_stop   (state == S_RUN && nxt == S_POST),
        .start_pend (start_pend),
        .stop_pend  (stop_pend)
    );

    // outputs
    always_comb begin
        line_q  = LS_STOP;
        data_go = 1'b0;
        unique case (state)
            S_IDLE, S_EXIT:  line_q = LS_STOP;
            S_PREP:          line_q = LS_BRIDGE;
            S_ZERO, S_TRAIL: line_q = LS_HS_ZERO;
            S_PRE, S_POST:   line_q = LS_HS_CLK;
            S_RUN: begin
                line_q  = LS_HS_CLK;
                data_go = 1'b1;
            end
            default:         line_q = LS_STOP;
        endcase
    end

    assign line_state = line_q;

    AST_READY_WHILE_TOGGLING: assert property (@(posedge clk) disable iff (!rst_n)
        data_go |-> line_state == LS_HS_CLK); // R4
    AST_READY_AFTER_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_go) |-> $past(line_state) == LS_HS_CLK); // R4
    AST_BRIDGE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LS_BRIDGE && $past(line_state) != LS_BRIDGE) |-> $past(line_state) == LS_STOP); // R2
    AST_STOP_FROM_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LS_STOP && $past(line_state) != LS_STOP) |-> $past(line_state) == LS_HS_ZERO); // R6
    AST_ZERO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LS_HS_ZERO && $past(line_state) != LS_HS_ZERO) |-> $past(line_state) != LS_STOP); // R3
    AST_DEFERRED_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_go && stop_pend) |=> !data_go); // R9

endmodule

// File: tb/dphy_clk_seq_test.sv
module dphy_clk_seq_test;
    import dphy_clk_pkg::*;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bs = 1'b0;
    logic         be = 1'b0;
    logic [W-1:0] cp = '0, cz = '0, cpr = '0, cpo = '0, ctr = '0, cx = '0;
    logic [1:0]   ls;
    logic         go;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    dphy_clk_seq #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .burst_start(bs), .burst_end(be),
        .cfg_prepare(cp), .cfg_zero(cz), .cfg_pre(cpr), .cfg_post(cpo),
        .cfg_trail(ctr), .cfg_exit(cx), .line_state(ls), .data_go(go)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        bs = 1'b0;
        be = 1'b0;
    endtask

    task automatic run_len(input logic [1:0] l, input logic r, output int n);
        n = 0;
        while (ls == l && go == r && n < 300) begin
            n++;
            step();
        end
    endtask

    function automatic int val(int d);
        return (d == 0) ? 0 : (d == 1) ? 1 : 4;
    endfunction

    initial begin
        int n;
        int prev_x;
        bit in_exit;
        prev_x  = 0;
        in_exit = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset line", int'(ls), int'(LS_STOP));
        chk("R1 reset ready", int'(go), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 5; c++) begin
            step();
            chk("R1 idle line", int'(ls), int'(LS_STOP));
        end
        for (int i = 0; i < 729; i++) begin
            int p, z, pr, po, tr, x, mode, k;
            p    = val(i % 3);
            z    = val((i / 3) % 3);
            pr   = val((i / 9) % 3);
            po   = val((i / 27) % 3);
            tr   = val((i / 81) % 3);
            x    = val((i / 243) % 3);
            mode = i % 3;
            k    = 1 + (i / 3) % 3;
            if (mode == 0 && in_exit) begin
                // R8: no new burst without a fresh start; R10: stray stop in LP-11
                be = 1'b1;
                for (int c = 0; c < prev_x + 4; c++) begin
                    chk("R8 no restart", int'(ls), int'(LS_STOP));
                    step();
                end
                in_exit = 0;
            end
            cp = W'(p); cz = W'(z); cpr = W'(pr); cpo = W'(po); ctr = W'(tr); cx = W'(x);
            bs = 1'b1;
            run_len(LS_STOP, 1'b0, n);
            chk("R7 R2 stop-state length", n, in_exit ? prev_x + 1 : 1);
            if (mode == 1) be = 1'b1;
            run_len(LS_BRIDGE, 1'b0, n);
            chk("R2 bridge length", n, p + 1);
            if (mode == 1) bs = 1'b1;
            run_len(LS_HS_ZERO, 1'b0, n);
            chk("R3 hs-zero length", n, z + 1);
            run_len(LS_HS_CLK, 1'b0, n);
            chk("R4 pre toggle length", n, pr + 1);
            n = 0;
            while (go && ls == LS_HS_CLK && n < 300) begin
                n++;
                if (mode == 2 && n == 1) bs = 1'b1;
                if (mode != 1 && n == k) be = 1'b1;
                step();
            end
            if (mode == 1)
                chk("R9 deferred stop ready length", n, 1);
            else
                chk("R5 R10 ready length", n, k);
            run_len(LS_HS_CLK, 1'b0, n);
            chk("R5 post toggle length", n, po + 1);
            run_len(LS_HS_ZERO, 1'b0, n);
            chk("R6 trail length", n, tr + 1);
            chk("R6 back to stop", int'(ls), int'(LS_STOP));
            chk("R6 ready low", int'(go), 0);
            in_exit = 1;
            prev_x  = x;
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule